// File: doc/BRIEF.md
# JTAG Test Access Port with Two-Bit Instruction Register

This block is the serial test port of a chip: a sixteen-state TAP controller stepped by TCK and TMS, a two-bit instruction register, a one-bit bypass path and a 32-bit identification register. It does not hold the boundary register. Instead it drives an external boundary chain with capture, shift and update strobes, a mode line for external test, and it takes that chain's serial output into its TDO multiplexer.

Four instructions are decoded from the two-bit code: external test, sample/preload, identification readout and bypass. Identification readout is the default after any reset, so a board tester can read the identity word without first loading an instruction. TDO is retimed to the falling edge of TCK and driven only while a shift state is active.

Top module: `jtag_tap_port`

## Requirements
- R1: After trst_n is asserted and released, tdo is 0, tdo_en is 0, bsr_extest is 0, no boundary strobe is high, and the identification instruction is selected.
- R2: Capture-IR loads the pattern 01 into the instruction shift stage. In Shift-IR that stage leaves on tdo least significant bit first while tdi fills it, and the new code takes effect on leaving Update-IR.
- R3: Instruction codes are 00 for external test, 01 for sample/preload, 10 for identification and 11 for bypass.
- R4: Under identification, Capture-DR loads the 32-bit word {version[3:0] at bits 31:28, part[13:0] at bits 27:14, variant[1:0] at bits 13:12, maker[10:0] at bits 11:1, constant 1 at bit 0}. It is shifted out least significant bit first, and tdi bits appear on tdo after 32 shifts.
- R5: Under bypass, a single stage captures 0 in Capture-DR and then delays tdi by one shift in Shift-DR.
- R6: Under external test and sample/preload, tdo in Shift-DR follows bsr_so. bsr_capture, bsr_shift and bsr_update are high only in Capture-DR, Shift-DR and Update-DR respectively, and only under these two instructions.
- R7: bsr_extest is high exactly when the current instruction is external test.
- R8: tdo changes on the falling edge of tck, and tdo_en is high only while the controller is in Shift-IR or Shift-DR.
- R9: Five rising tck edges with tms high bring the controller to Test-Logic-Reset from any state, and that state reloads the identification instruction.
- R10: trst_n low resets the port at once and disables tdo. Its release takes effect through a two-stage synchronizer clocked by tck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | Output enable for tdo |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_extest | output | 1 | Boundary cells drive the pins (external test mode) |

## Verification
Two events can fall on the same tck edge. The first is the last data shift, which coincides with the move into Exit1 that drops tdo_en on the following falling edge. The second is the five-high tms escape, which can arrive in the middle of a bypass or boundary shift just as Test-Logic-Reset overwrites the instruction. The bench leaves every scan on its last bit with tms high, and it checks both the bit count returned and tdo_en in Run-Test/Idle. It also escapes from Shift-DR under bypass with five tms-high edges, then confirms by a 32-bit read that the identification word has been restored. A trst_n assertion is also made while tdo_en is high, and tdo_en is judged before the next clock edge.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;
  localparam int IR_W = 2;
  localparam int ID_W = 32;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 2'b01;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [IR_W-1:0] {
    INS_EXTEST = 2'b00,
    INS_SAMPLE = 2'b01,
    INS_IDCODE = 2'b10,
    INS_BYPASS = 2'b11
  } tap_instr_e;
endpackage

// File: rtl/jtag_tap_rstsync.sv
module jtag_tap_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_TLR;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sr,
  output tap_instr_e      instr
);
  logic [IR_W-1:0] sr_q, sr_d;
  logic            sr_en;
  tap_instr_e      ins_q, ins_d;
  logic            ins_en;

  always_comb begin
    sr_en = 1'b0;
    sr_d  = sr_q;
    if (state == ST_CAP_IR) begin
      sr_en = 1'b1;
      sr_d  = IR_CAPTURE_PAT;
    end else if (state == ST_SH_IR) begin
      sr_en = 1'b1;
      sr_d  = {tdi, sr_q[IR_W-1:1]};
    end
  end

  always_comb begin
    ins_en = 1'b0;
    ins_d  = ins_q;
    if (state == ST_TLR) begin
      ins_en = 1'b1;
      ins_d  = INS_IDCODE;
    end else if (state == ST_UPD_IR) begin
      ins_en = 1'b1;
      ins_d  = tap_instr_e'(sr_q);
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      ins_q <= INS_IDCODE;
    end else begin
      if (sr_en)  sr_q  <= sr_d;
      if (ins_en) ins_q <= ins_d;
    end
  end

  assign ir_sr = sr_q;
  assign instr = ins_q;
endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  tap_instr_e instr,
  input  logic       tdi,
  output logic       byp_q,
  output logic       id_lsb
);
  logic            byp_d, byp_en;
  logic [ID_W-1:0] id_q, id_d;
  logic            id_en;

  always_comb begin
    byp_en = 1'b0;
    byp_d  = byp_q;
    if (instr == INS_BYPASS) begin
      if (state == ST_CAP_DR) begin
        byp_en = 1'b1;
        byp_d  = 1'b0;
      end else if (state == ST_SH_DR) begin
        byp_en = 1'b1;
        byp_d  = tdi;
      end
    end
  end

  always_comb begin
    id_en = 1'b0;
    id_d  = id_q;
    if (instr == INS_IDCODE) begin
      if (state == ST_CAP_DR) begin
        id_en = 1'b1;
        id_d  = ID_VALUE;
      end else if (state == ST_SH_DR) begin
        id_en = 1'b1;
        id_d  = {tdi, id_q[ID_W-1:1]};
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
    end else begin
      if (byp_en) byp_q <= byp_d;
      if (id_en)  id_q  <= id_d;
    end
  end

  assign id_lsb = id_q[0];
endmodule

// File: rtl/jtag_tap_port.sv
module jtag_tap_port
  import jtag_tap_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h3,
  parameter logic [13:0] ID_PART    = 14'h2B6D,
  parameter logic [1:0]  ID_VARIANT = 2'h2,
  parameter logic [10:0] ID_MAKER   = 11'h49A,
  parameter int          SYNC_STAGES = 2
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_en,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic bsr_extest
);
  localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_VARIANT, ID_MAKER, 1'b1};

  logic            rst_n_s;
  tap_state_e      state_q;
  tap_instr_e      instr_q;
  logic [IR_W-1:0] ir_sr;
  logic            byp_q, id_lsb;
  logic            bsel, shifting, tdo_d;
  logic            tdo_q, tdo_en_q;

  jtag_tap_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(tck), .arst_n(trst_n), .rst_n(rst_n_s)
  );

  jtag_tap_fsm u_fsm (
    .tck(tck), .rst_n(rst_n_s), .tms(tms), .state(state_q)
  );

  jtag_tap_ir u_ir (
    .tck(tck), .rst_n(rst_n_s), .state(state_q), .tdi(tdi),
    .ir_sr(ir_sr), .instr(instr_q)
  );

  jtag_tap_dr #(.ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .rst_n(rst_n_s), .state(state_q), .instr(instr_q), .tdi(tdi),
    .byp_q(byp_q), .id_lsb(id_lsb)
  );

  assign bsel     = (instr_q == INS_EXTEST) || (instr_q == INS_SAMPLE);
  assign shifting = (state_q == ST_SH_IR) || (state_q == ST_SH_DR);

  always_comb begin
    tdo_d = tdo_q;
    if (state_q == ST_SH_IR) begin
      tdo_d = ir_sr[0];
    end else if (state_q == ST_SH_DR) begin
      case (instr_q)
        INS_BYPASS: tdo_d = byp_q;
        INS_IDCODE: tdo_d = id_lsb;
        default:    tdo_d = bsr_so;
      endcase
    end
  end

  always_ff @(negedge tck or negedge rst_n_s) begin
    if (!rst_n_s) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_en_q <= shifting;
      if (shifting) tdo_q <= tdo_d;
    end
  end

  assign tdo         = tdo_q;
  assign tdo_en      = tdo_en_q;
  assign bsr_capture = bsel && (state_q == ST_CAP_DR);
  assign bsr_shift   = bsel && (state_q == ST_SH_DR);
  assign bsr_update  = bsel && (state_q == ST_UPD_DR);
  assign bsr_extest  = (instr_q == INS_EXTEST);
endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
  import jtag_tap_pkg::*;
(
  input logic            tck,
  input logic            rst_n,
  input logic            tms,
  input tap_state_e      state,
  input tap_instr_e      instr,
  input logic [IR_W-1:0] ir_sr,
  input logic            byp_q,
  input logic            tdo_en,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update
);
  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                      hi_cnt <= '0;
    else if (!tms)                   hi_cnt <= '0;
    else if (hi_cnt != 3'd5)         hi_cnt <= hi_cnt + 3'd1;
  end

  // R8
  tdo_en_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

  // R2
  ir_capture_pat_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $past(state == ST_CAP_IR) |-> (ir_sr == IR_CAPTURE_PAT));

  // R9
  tlr_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $past(state == ST_TLR) |-> (instr == INS_IDCODE));

  // R9
  five_tms_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_cnt == 3'd5) |-> (state == ST_TLR));

  // R5
  bypass_zero_chk: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(state == ST_CAP_DR) && instr == INS_BYPASS) |-> !byp_q);

  // R6
  strobe_excl_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));
endmodule

bind jtag_tap_port jtag_tap_chk chk_i (
  .tck(tck), .rst_n(rst_n_s), .tms(tms), .state(state_q), .instr(instr_q),
  .ir_sr(ir_sr), .byp_q(byp_q), .tdo_en(tdo_en),
  .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update)
);

// File: tb/jtag_tap_port_tb.sv
module jtag_tap_port_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam logic [31:0] EXP_ID = {4'h3, 14'h2B6D, 2'h2, 11'h49A, 1'b1};
  localparam logic [7:0]  BS_PAT = 8'hA5;

  logic tck = 1'b0;
  logic trst_n, tms, tdi;
  logic tdo, tdo_en, bsr_capture, bsr_shift, bsr_update, bsr_extest;
  logic [7:0] bs_chain;
  int upd_cnt;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) tck = ~tck;

  jtag_tap_port dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bs_chain[0]),
    .tdo(tdo), .tdo_en(tdo_en), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .bsr_extest(bsr_extest)
  );

  // Bench model of the external boundary chain
  always @(posedge tck) begin
    if (bsr_capture)    bs_chain <= BS_PAT;
    else if (bsr_shift) bs_chain <= {tdi, bs_chain[7:1]};
    if (bsr_update)     upd_cnt <= upd_cnt + 1;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic tms_v, logic tdi_v);
    tms = tms_v;
    tdi = tdi_v;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic scan_ir(logic [1:0] code, output logic [1:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    check("R8 tdo_en in Shift-IR", 64'(tdo_en), 64'd1);
    for (int i = 0; i < 2; i++) begin
      cap[i] = tdo;
      step(i == 1, code[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(int n, logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [63:0] exp_scan(logic [1:0] code, int n, logic [63:0] din);
    logic [63:0] r;
    case (code)
      2'b10:   r = {din[31:0], EXP_ID};
      2'b11:   r = {din[62:0], 1'b0};
      default: r = {din[55:0], BS_PAT};
    endcase
    for (int i = 0; i < 64; i++) if (i >= n) r[i] = 1'b0;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL WDOG run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [1:0]  cap;
    logic [63:0] dout, din;
    int          seed_dummy;
    int          u0;
    seed_dummy = $urandom(32'h5EED_0107);
    upd_cnt = 0;
    bs_chain = '0;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    #(CLK_PERIOD * 3 + 1);
    trst_n = 1'b1;
    repeat (4) step(1, 0);

    // R1 reset state
    check("R1 tdo", 64'(tdo), 64'd0);
    check("R1 tdo_en", 64'(tdo_en), 64'd0);
    check("R1 extest", 64'(bsr_extest), 64'd0);
    check("R1 strobes", 64'({bsr_capture, bsr_shift, bsr_update}), 64'd0);
    step(0, 0);
    check("R8 tdo_en idle", 64'(tdo_en), 64'd0);
    din = 64'h0123_4567_89AB_CDEF;
    scan_dr(40, din, dout);
    check("R1 R4 default idcode", dout, exp_scan(2'b10, 40, din));

    // R2 R3 R5 directed bypass
    scan_ir(2'b11, cap);
    check("R2 capture pattern", 64'(cap), 64'd1);
    check("R7 bypass no extest", 64'(bsr_extest), 64'd0);
    u0 = upd_cnt;
    din = 64'h0000_0000_0000_0F0F;
    scan_dr(16, din, dout);
    check("R5 bypass delay", dout, exp_scan(2'b11, 16, din));
    check("R6 no update under bypass", 64'(upd_cnt - u0), 64'd0);

    // R6 R7 directed external test
    scan_ir(2'b00, cap);
    check("R7 extest high", 64'(bsr_extest), 64'd1);
    u0 = upd_cnt;
    din = 64'h0000_0000_00C3_3C5A;
    scan_dr(20, din, dout);
    check("R6 boundary path", dout, exp_scan(2'b00, 20, din));
    check("R6 one update strobe", 64'(upd_cnt - u0), 64'd1);

    // R9 escape from Shift-DR under bypass
    scan_ir(2'b11, cap);
    step(1, 0); step(0, 0); step(0, 0);
    check("R8 tdo_en in Shift-DR", 64'(tdo_en), 64'd1);
    repeat (5) step(1, 1);
    check("R9 extest low after escape", 64'(bsr_extest), 64'd0);
    step(0, 0);
    din = 64'h0;
    scan_dr(32, din, dout);
    check("R9 idcode restored", dout, exp_scan(2'b10, 32, din));

    // R10 asynchronous reset during Shift-DR
    scan_ir(2'b01, cap);
    step(1, 0); step(0, 0); step(0, 0);
    check("R8 tdo_en before trst", 64'(tdo_en), 64'd1);
    #3;
    trst_n = 1'b0;
    #1;
    check("R10 tdo_en drops async", 64'(tdo_en), 64'd0);
    check("R10 extest cleared", 64'(bsr_extest), 64'd0);
    @(negedge tck);
    #1;
    trst_n = 1'b1;
    repeat (3) step(1, 0);
    step(0, 0);
    din = 64'hFFFF_FFFF_FFFF_FFFF;
    scan_dr(36, din, dout);
    check("R10 idcode after trst", dout, exp_scan(2'b10, 36, din));

    // Random instruction / data mix
    for (int it = 0; it < 40; it++) begin
      logic [1:0] code;
      int n;
      code = 2'($urandom % 4);
      n = 4 + int'($urandom % 40);
      din = {$urandom, $urandom};
      scan_ir(code, cap);
      check("R2 random capture", 64'(cap), 64'd1);
      check("R3 R7 random extest", 64'(bsr_extest), 64'(code == 2'b00));
      u0 = upd_cnt;
      scan_dr(n, din, dout);
      check("R3 R4 R5 R6 random scan", dout, exp_scan(code, n, din));
      check("R6 random update count", 64'(upd_cnt - u0), 64'(code[1] == 1'b0));
      check("R8 idle tdo_en", 64'(tdo_en), 64'd0);
    end

    summary();
    $finish;
  end
endmodule